// File: doc/BRIEF.md
# Radix-2 Delay-Feedback Butterfly Stage

This block is one stage of a single-path delay-feedback pipeline FFT using decimation in frequency. It accepts one complex sample per transfer from a normal-order stream and pairs it with the sample that arrived `D` transfers earlier. Pairing uses a feedback delay line of depth `D`. The stream runs continuously across transform boundaries with no idle gap. In a chain, `D` is N/2 in the first stage of an N-point transform and halves at each stage after that, down to 1.

Each period of 2D accepted samples has two halves. In the first half (load), a new sample goes into the delay line and the value leaving the line goes out unchanged. In the second half (combine), the stage outputs the sum of the delayed value and the new sample. It writes their difference back into the line, and that difference comes out during the next load half. When `rot_en` is high, the stage acts as the second member of a radix-2² pair. It multiplies by -j the outputs produced in the last quarter of every 4D-sample block, so that a single complex multiplier after the pair is enough. Results are one bit wider than the inputs, so no sum or difference can overflow.

Both sides use valid/ready. The stage holds no buffer at its edge. A transfer happens when `in_valid` and `out_ready` are both high. The output is valid exactly when the input is valid. Back-pressure from `out_ready` passes straight through to `in_ready`. When no transfer happens, the internal state stays unchanged.

Top module: `r2sdf_stage`

## Requirements
- R1: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle. The counter and the delay line advance only on a cycle with `in_valid && out_ready`.
- R2: A synchronous active-high `rst` clears the position counter and every delay-line entry. The first D outputs after reset are therefore zero.
- R3: When the accepted-sample index k satisfies (k mod 2D) < D, the input is stored in the delay line.
- R4: When D ≤ (k mod 2D) < 2D, the output equals the value stored D samples earlier plus the current input. The sum is computed at W+1 bits.
- R5: During the combine half, (stored − input) is written back. It is output unchanged D samples later, in the next load half, at the same offset.
- R6: With `rot_en` high and 3D ≤ (k mod 4D) < 4D, the output is the sum multiplied by -j. The output real part equals the imaginary part of the sum, and the output imaginary part equals the negated real part of the sum, taken modulo 2^(W+1).
- R7: With `rot_en` low, no position is rotated, including the last quarter.
- R8: Stalled cycles (`in_valid` high, `out_ready` low) present the same output as the transfer that follows, and they do not change the pairing of samples.
- R9: Full-scale inputs, either all at −2^(W−1) or all at 2^(W−1)−1, give exact sums and differences without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rot_en | input | 1 | Enables the -j rotation on the last quarter of each 4D block |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Stage can take a sample (follows out_ready) |
| in_re | input | W | Input real part, two's complement |
| in_im | input | W | Input imaginary part, two's complement |
| out_ready | input | 1 | Downstream can take a result |
| out_valid | output | 1 | Result valid (follows in_valid) |
| out_re | output | W+1 | Result real part |
| out_im | output | W+1 | Result imaginary part |

## Verification
In one cycle of the last quarter of a 4D block, with `rot_en` high, three things happen together. The sum goes out rotated, the unrotated difference goes back into the line, and the counter wraps from 4D−1 to 0. The bench provokes this with random stalls and random toggling of `rot_en` around those positions. It judges every output against a model that tracks only the accepted-sample count. A wrong write-back is exposed D samples later, when the stored difference reappears in the load half. A wrong wrap is exposed by the misaligned pairing that follows it.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  typedef enum logic {
    PH_LOAD    = 1'b0,
    PH_COMBINE = 1'b1
  } sdf_phase_e;
endpackage

// File: rtl/sdf_seq_ctrl.sv
module sdf_seq_ctrl #(
  parameter int LD = 4,
  parameter int CW = LD + 2,
  parameter int AW = (LD == 0) ? 1 : LD
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  output logic [CW-1:0]        cnt_o,
  output logic [AW-1:0]        addr_o,
  output sdf_pkg::sdf_phase_e  phase_o,
  output logic                 lastq_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (LD == 0) begin : g_single
      assign addr_o = '0;
    end else begin : g_multi
      assign addr_o = cnt_q[AW-1:0];
    end
  endgenerate

  assign cnt_o   = cnt_q;
  assign phase_o = sdf_pkg::sdf_phase_e'(cnt_q[LD]);
  assign lastq_o = cnt_q[LD] & cnt_q[LD+1];
endmodule

// File: rtl/sdf_delay_line.sv
module sdf_delay_line #(
  parameter int DW = 34,
  parameter int D  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < D; i++) mem[i] <= '0;
    end else if (adv) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/sdf_bfly_core.sv
module sdf_bfly_core #(
  parameter int W = 16
) (
  input  sdf_pkg::sdf_phase_e  phase,
  input  logic                 rot,
  input  logic signed [W-1:0]  in_re,
  input  logic signed [W-1:0]  in_im,
  input  logic signed [W:0]    dly_re,
  input  logic signed [W:0]    dly_im,
  output logic signed [W:0]    res_re,
  output logic signed [W:0]    res_im,
  output logic signed [W:0]    wb_re,
  output logic signed [W:0]    wb_im
);
  logic signed [W:0] x_re, x_im, sum_re, sum_im, dif_re, dif_im;

  assign x_re   = (W+1)'(in_re);
  assign x_im   = (W+1)'(in_im);
  assign sum_re = dly_re + x_re;
  assign sum_im = dly_im + x_im;
  assign dif_re = dly_re - x_re;
  assign dif_im = dly_im - x_im;

  always_comb begin
    if (phase == sdf_pkg::PH_LOAD) begin
      res_re = dly_re;
      res_im = dly_im;
      wb_re  = x_re;
      wb_im  = x_im;
    end else begin
      wb_re = dif_re;
      wb_im = dif_im;
      if (rot) begin
        res_re = sum_im;
        res_im = -sum_re;
      end else begin
        res_re = sum_re;
        res_im = sum_im;
      end
    end
  end
endmodule

// File: rtl/r2sdf_stage.sv
module r2sdf_stage #(
  parameter int W = 16,
  parameter int D = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rot_en,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_re,
  input  logic signed [W-1:0] in_im,
  input  logic                out_ready,
  output logic                out_valid,
  output logic signed [W:0]   out_re,
  output logic signed [W:0]   out_im
);
  localparam int LD = $clog2(D);
  localparam int CW = LD + 2;
  localparam int AW = (LD == 0) ? 1 : LD;
  localparam int DW = 2 * (W + 1);

  logic                 adv, lastq, rot_act;
  logic [CW-1:0]        cnt_q;
  logic [AW-1:0]        addr;
  sdf_pkg::sdf_phase_e  phase;
  logic [DW-1:0]        rd_word, wr_word;
  logic signed [W:0]    wr_re, wr_im;

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign adv       = in_valid & out_ready;
  assign rot_act   = rot_en & lastq;

  sdf_seq_ctrl #(.LD(LD), .CW(CW), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .adv(adv),
    .cnt_o(cnt_q), .addr_o(addr), .phase_o(phase), .lastq_o(lastq)
  );

  assign wr_word = {wr_re, wr_im};

  sdf_delay_line #(.DW(DW), .D(D), .AW(AW)) u_dly (
    .clk(clk), .rst(rst), .adv(adv), .addr(addr),
    .wdata(wr_word), .rdata(rd_word)
  );

  sdf_bfly_core #(.W(W)) u_core (
    .phase(phase), .rot(rot_act),
    .in_re(in_re), .in_im(in_im),
    .dly_re(rd_word[DW-1:W+1]), .dly_im(rd_word[W:0]),
    .res_re(out_re), .res_im(out_im),
    .wb_re(wr_re), .wb_im(wr_im)
  );
endmodule

// File: rtl/r2sdf_stage_chk.sv
module r2sdf_stage_chk #(
  parameter int W  = 16,
  parameter int CW = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_ready,
  input logic                out_valid,
  input logic                combine,
  input logic                rot_act,
  input logic signed [W-1:0] in_re,
  input logic signed [W:0]   out_re,
  input logic signed [W:0]   wr_re,
  input logic [CW-1:0]       cnt
);
  logic signed [W:0] twice_in, expect_wb;
  assign twice_in  = {in_re, 1'b0};
  assign expect_wb = out_re - twice_in;

  assert_handshake_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid == in_valid) && (in_ready == out_ready));

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && out_ready) |=> $stable(cnt));

  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_ready) |=> cnt == $past(cnt) + 1'b1);

  assert_reset_clear_R2: assert property (@(posedge clk)
    $fell(rst) |-> cnt == '0);

  assert_writeback_R5: assert property (@(posedge clk) disable iff (rst)
    (combine && !rot_act) |-> wr_re == expect_wb);
endmodule

bind r2sdf_stage r2sdf_stage_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_ready(out_ready), .out_valid(out_valid),
  .combine(phase == sdf_pkg::PH_COMBINE), .rot_act(rot_act),
  .in_re(in_re), .out_re(out_re), .wr_re(wr_re), .cnt(cnt_q)
);

// File: tb/r2sdf_stage_test.sv
module r2sdf_stage_test;
  localparam int W = 12;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst, rot_en, in_valid, out_ready, in_ready, out_valid;
  logic signed [W-1:0] in_re, in_im;
  logic signed [W:0]   out_re, out_im;

  int checks = 0;
  int fails  = 0;
  int m_re [D];
  int m_im [D];
  int mcnt;
  string tag;

  always #2.5 clk = ~clk;

  r2sdf_stage #(.W(W), .D(D)) uut (
    .clk(clk), .rst(rst), .rot_en(rot_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
    .out_ready(out_ready), .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  function automatic int wrap(input int v);
    int m;
    m = v & ((1 << (W + 1)) - 1);
    if (m >= (1 << W)) m = m - (1 << (W + 1));
    return m;
  endfunction

  function automatic int rnd_s();
    return int'($urandom_range(0, (1 << W) - 1)) - (1 << (W - 1));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < D; i++) begin m_re[i] = 0; m_im[i] = 0; end
    mcnt = 0;
  endtask

  task automatic step(input logic v, input logic rdy, input logic rot, input int xr, input int xi);
    int pos, a, e_re, e_im, s_re, s_im;
    bit comb;
    @(negedge clk);
    in_valid = v; out_ready = rdy; rot_en = rot;
    in_re = W'(xr); in_im = W'(xi);
    #1;
    check("R1 valid", int'(out_valid), int'(v));
    check("R1 ready", int'(in_ready), int'(rdy));
    if (v) begin
      pos  = mcnt % (4 * D);
      a    = mcnt % D;
      comb = (pos % (2 * D)) >= D;
      if (!comb) begin
        e_re = m_re[a]; e_im = m_im[a];
        tag = "R3 R5 load";
      end else begin
        s_re = wrap(m_re[a] + xr); s_im = wrap(m_im[a] + xi);
        if (rot && pos >= 3 * D) begin
          e_re = s_im; e_im = wrap(-s_re); tag = "R6 rotate";
        end else begin
          e_re = s_re; e_im = s_im;
          tag = (pos >= 3 * D) ? "R7 no-rotate" : "R4 combine";
        end
      end
      if (!rdy) tag = {tag, " R8 stall"};
      check(tag, int'(out_re), e_re);
      check(tag, int'(out_im), e_im);
      if (rdy) begin
        if (!comb) begin m_re[a] = xr; m_im[a] = xi; end
        else begin m_re[a] = wrap(m_re[a] - xr); m_im[a] = wrap(m_im[a] - xi); end
        mcnt++;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R2 reset valid", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    logic rot;
    seed = int'($urandom(32'd4242));
    rst = 1'b1; rot_en = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_re = '0; in_im = '0;
    model_reset();
    do_reset();
    // R2: first D outputs after reset are zero (model memory is zero)
    for (int i = 0; i < D; i++) step(1'b1, 1'b1, 1'b0, rnd_s(), rnd_s());
    // R7: rotation disabled over several full blocks
    for (int i = 0; i < 8 * D; i++) step(1'b1, 1'b1, 1'b0, rnd_s(), rnd_s());
    // R6: rotation enabled, continuous stream
    for (int i = 0; i < 8 * D; i++) step(1'b1, 1'b1, 1'b1, rnd_s(), rnd_s());
    // R1 R8: random valid, ready and rotate mode
    rot = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 63) == 0) rot = ~rot;
      step($urandom_range(0, 9) < 8, $urandom_range(0, 9) < 7, rot, rnd_s(), rnd_s());
    end
    // R9: full-scale negative then positive, with rotation
    do_reset();
    for (int i = 0; i < 4 * D; i++) step(1'b1, 1'b1, 1'b1, -(1 << (W - 1)), -(1 << (W - 1)));
    for (int i = 0; i < 4 * D; i++) step(1'b1, 1'b1, 1'b1, (1 << (W - 1)) - 1, -(1 << (W - 1)));
    for (int i = 0; i < 4 * D; i++) step(1'b1, 1'b1, 1'b0, (1 << (W - 1)) - 1, (1 << (W - 1)) - 1);
    // R2: reset mid-block restarts pairing
    for (int i = 0; i < D + 3; i++) step(1'b1, 1'b1, 1'b0, rnd_s(), rnd_s());
    do_reset();
    for (int i = 0; i < 4 * D; i++) step(1'b1, $urandom_range(0, 3) != 0, 1'b1, rnd_s(), rnd_s());
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule